// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host access to the byte-wide registers of a two-wire bus controller through a single 64-bit command/status word. The host writes one word holding a start flag, a direction flag, a primary opcode, an extended selector and a data byte. While the start flag reads set, the bridge is busy with exactly one access to the inner register file. When that access finishes, the bridge clears the flag. For a read, it also places the register byte in the low byte of the word.

Software polls the word until the start flag reads zero and only then issues the next access. Register selection has two levels. The primary opcode names one register directly, or it hands the choice to the extended selector. One extended selector is shared: on a write it reaches the clock-control register, and on a read it returns the controller status. In this block the inner register file is a stub. Its registers drive outputs toward the protocol engine, and the status byte comes in from that engine.

Top module: `ireg_bridge`

## Requirements
- R1: After reset the command word reads all zero. The divisor register reads 0x18 and the data, control and clock-control registers read 0x00.
- R2: A host write with bit 63 set, made while bit 63 of the word is clear, is accepted. From the next cycle the word reads back exactly the value written.
- R3: After an accepted command, bit 63 stays set for exactly LATENCY cycles (default 4) and then clears.
- R4: A host write made while bit 63 of the word is set is ignored, including in the last busy cycle. The word and the inner registers stay as the running access leaves them.
- R5: A host write with bit 63 clear, made while the word is idle, is ignored and the word keeps its value.
- R6: Opcode 4 in bits 60:57 selects the clock divisor register. A write loads bits 7:0 into it, and a read returns it.
- R7: Opcode 6 with extended selector 1 in bits 34:32 selects the data register. Opcode 6 with selector 2 selects the control register. Both can be written and read back.
- R8: With opcode 6 and selector 3, a write loads the clock-control register and a read returns the status input.
- R9: A write with opcode 6 and selector 7 returns the divisor, data, control and clock-control registers to their reset values.
- R10: Any other opcode or selector still completes after LATENCY cycles. A write to it changes no register, and a read from it returns 0x00.
- R11: Bit 56 set means a read and bit 56 clear means a write. On completion of a read, bits 7:0 hold the register byte. On completion of a write, bits 7:0 keep the written byte. All other bits except bit 63 keep the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host writes the command word this cycle |
| host_wdata_i | input | 64 | Command word written by the host |
| host_word_o | output | 64 | Command/status word as the host reads it |
| status_i | input | 8 | Controller status byte, returned by status reads |
| div_o | output | 8 | Clock divisor register |
| clkctl_o | output | 8 | Clock-control register |
| ctl_o | output | 8 | Control register |
| data_o | output | 8 | Data register |

## Verification
Two events can fall in the same cycle: the completion of a running access and a new host write. The new write still sees the start flag set in that cycle, so it must be dropped. The bench provokes this by driving a second command exactly in the last busy cycle of the first. The collision is judged at the ports: after completion, the word must show the first command with its flag cleared, and the data register must hold the first command's byte, never the second's.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  localparam int WORD_W   = 64;
  localparam int BYTE_W   = 8;
  localparam int VLD_BIT  = 63;
  localparam int RD_BIT   = 56;
  localparam int OP_LSB   = 57;
  localparam int OP_W     = 4;
  localparam int EXT_LSB  = 32;
  localparam int EXT_W    = 3;

  localparam logic [OP_W-1:0]  OP_DIV   = 4'd4;
  localparam logic [OP_W-1:0]  OP_EXT   = 4'd6;
  localparam logic [EXT_W-1:0] EXT_DATA = 3'd1;
  localparam logic [EXT_W-1:0] EXT_CTL  = 3'd2;
  localparam logic [EXT_W-1:0] EXT_CLK  = 3'd3;
  localparam logic [EXT_W-1:0] EXT_SRST = 3'd7;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_DIV,
    TGT_DATA,
    TGT_CTL,
    TGT_CLK,
    TGT_SRST
  } tgt_e;
endpackage

// File: rtl/ireg_decode.sv
module ireg_decode
  import ireg_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [EXT_W-1:0] ext_i,
  output tgt_e             tgt_o
);
  always_comb begin
    tgt_o = TGT_NONE;
    if (op_i == OP_DIV) begin
      tgt_o = TGT_DIV;
    end else if (op_i == OP_EXT) begin
      unique case (ext_i)
        EXT_DATA: tgt_o = TGT_DATA;
        EXT_CTL:  tgt_o = TGT_CTL;
        EXT_CLK:  tgt_o = TGT_CLK;
        EXT_SRST: tgt_o = TGT_SRST;
        default:  tgt_o = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ireg_seq.sv
module ireg_seq #(
  parameter int LATENCY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  assign done_o = active_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (done_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ireg_regs.sv
module ireg_regs
  import ireg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DIV_RST = 8'h18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              rd_i,
  input  tgt_e              tgt_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [BYTE_W-1:0] div_o,
  output logic [BYTE_W-1:0] clkctl_o,
  output logic [BYTE_W-1:0] ctl_o,
  output logic [BYTE_W-1:0] data_o
);
  logic wr_en;
  assign wr_en = acc_i && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o    <= DIV_RST;
      clkctl_o <= '0;
      ctl_o    <= '0;
      data_o   <= '0;
    end else if (wr_en) begin
      unique case (tgt_i)
        TGT_DIV:  div_o    <= wdata_i;
        TGT_DATA: data_o   <= wdata_i;
        TGT_CTL:  ctl_o    <= wdata_i;
        TGT_CLK:  clkctl_o <= wdata_i;
        TGT_SRST: begin
          div_o    <= DIV_RST;
          clkctl_o <= '0;
          ctl_o    <= '0;
          data_o   <= '0;
        end
        default: ;
      endcase
    end
  end

  // selector 3 is shared: writes hit clock control, reads see status
  always_comb begin
    unique case (tgt_i)
      TGT_DIV:  rdata_o = div_o;
      TGT_DATA: rdata_o = data_o;
      TGT_CTL:  rdata_o = ctl_o;
      TGT_CLK:  rdata_o = status_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
  import ireg_pkg::*;
#(
  parameter int                LATENCY = 4,
  parameter logic [BYTE_W-1:0] DIV_RST = 8'h18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_word_o,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] div_o,
  output logic [BYTE_W-1:0] clkctl_o,
  output logic [BYTE_W-1:0] ctl_o,
  output logic [BYTE_W-1:0] data_o
);
  logic [WORD_W-1:0] word_q;
  logic              accept;
  logic              done;
  tgt_e              tgt;
  logic [BYTE_W-1:0] rdata;

  assign host_word_o = word_q;
  // busy word swallows any host write, also in its final cycle
  assign accept = host_wr_i && !word_q[VLD_BIT] && host_wdata_i[VLD_BIT];

  ireg_decode u_dec (
    .op_i  (word_q[OP_LSB +: OP_W]),
    .ext_i (word_q[EXT_LSB +: EXT_W]),
    .tgt_o (tgt)
  );

  ireg_seq #(.LATENCY(LATENCY)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .done_o  (done)
  );

  ireg_regs #(.DIV_RST(DIV_RST)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (done),
    .rd_i     (word_q[RD_BIT]),
    .tgt_i    (tgt),
    .wdata_i  (word_q[BYTE_W-1:0]),
    .status_i (status_i),
    .rdata_o  (rdata),
    .div_o    (div_o),
    .clkctl_o (clkctl_o),
    .ctl_o    (ctl_o),
    .data_o   (data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (accept) begin
      word_q <= host_wdata_i;
    end else if (done) begin
      word_q[VLD_BIT] <= 1'b0;
      if (word_q[RD_BIT]) word_q[BYTE_W-1:0] <= rdata;
    end
  end
endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk #(
  parameter int LATENCY = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_wr_i,
  input logic [63:0] host_wdata_i,
  input logic [63:0] host_word_o,
  input logic [7:0]  div_o,
  input logic [7:0]  clkctl_o,
  input logic [7:0]  ctl_o,
  input logic [7:0]  data_o
);
  localparam int RW = $clog2(LATENCY + 2) + 1;

  logic          vld;
  logic [RW-1:0] run_q;

  assign vld = host_word_o[63];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (vld && run_q < RW'(LATENCY + 1)) run_q <= run_q + 1'b1;
    else if (!vld) run_q <= '0;
  end

  p_busy_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld |-> run_q < RW'(LATENCY));

  p_busy_exact_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vld) |-> $past(run_q) == RW'(LATENCY - 1));

  p_accept_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !vld && host_wdata_i[63]) |=> host_word_o == $past(host_wdata_i));

  p_busy_ignore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld && run_q < RW'(LATENCY - 1)) |=> ($stable(host_word_o) && $stable(div_o)
      && $stable(clkctl_o) && $stable(ctl_o) && $stable(data_o)));

  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld && !(host_wr_i && host_wdata_i[63])) |=> $stable(host_word_o));
endmodule

bind ireg_bridge ireg_bridge_chk #(.LATENCY(LATENCY)) u_chk (.*);

// File: tb/ireg_bridge_test.sv
module ireg_bridge_test;
  localparam int LAT = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_wr_i = 1'b0;
  logic [63:0] host_wdata_i = '0;
  logic [63:0] host_word_o;
  logic [7:0]  status_i = 8'h00;
  logic [7:0]  div_o, clkctl_o, ctl_o, data_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  ireg_bridge #(.LATENCY(LAT)) uut (
    .clk_i, .rst_ni, .host_wr_i, .host_wdata_i, .host_word_o,
    .status_i, .div_o, .clkctl_o, .ctl_o, .data_o
  );

  function automatic logic [63:0] mk(input bit rd, input logic [3:0] op,
                                     input logic [2:0] ext, input logic [7:0] b);
    logic [63:0] w;
    w = 64'h0000_1234_0000_5600;
    w[63] = 1'b1;
    w[56] = rd;
    w[60:57] = op;
    w[34:32] = ext;
    w[7:0] = b;
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] w);
    @(negedge clk_i);
    host_wr_i = 1'b1;
    host_wdata_i = w;
    @(negedge clk_i);
    host_wr_i = 1'b0;
  endtask

  task automatic wait_idle(output logic [63:0] w);
    for (int i = 0; i < 20 && host_word_o[63]; i++) @(negedge clk_i);
    w = host_word_o;
  endtask

  task automatic access(input logic [63:0] c, output logic [63:0] w);
    issue(c);
    wait_idle(w);
  endtask

  function automatic logic [63:0] done_of(input logic [63:0] c, input logic [7:0] rb);
    logic [63:0] w;
    w = c;
    w[63] = 1'b0;
    if (c[56]) w[7:0] = rb;
    return w;
  endfunction

  task automatic t_reset();
    chk("R1 word", host_word_o, 64'h0);
    chk("R1 div", 64'(div_o), 64'h18);
    chk("R1 data", 64'(data_o), 64'h0);
    chk("R1 ctl", 64'(ctl_o), 64'h0);
    chk("R1 clkctl", 64'(clkctl_o), 64'h0);
  endtask

  task automatic t_timing();
    logic [63:0] c, w;
    int vcnt;
    c = mk(0, 4'd6, 3'd1, 8'hA5);
    issue(c);
    chk("R2 accepted word", host_word_o, c);
    vcnt = 0;
    for (int i = 0; i < 20 && host_word_o[63]; i++) begin
      vcnt++;
      @(negedge clk_i);
    end
    chk("R3 busy cycles", 64'(vcnt), 64'(LAT));
    w = host_word_o;
    chk("R11 write completion word", w, done_of(c, 8'h00));
    chk("R7 data write", 64'(data_o), 64'hA5);
  endtask

  task automatic t_div();
    logic [63:0] c, w;
    c = mk(0, 4'd4, 3'd0, 8'h3C);
    access(c, w);
    chk("R6 div write", 64'(div_o), 64'h3C);
    c = mk(1, 4'd4, 3'd0, 8'hC3);
    access(c, w);
    chk("R6 R11 div read", w, done_of(c, 8'h3C));
  endtask

  task automatic t_ctl_data();
    logic [63:0] c, w;
    access(mk(0, 4'd6, 3'd2, 8'h44), w);
    chk("R7 ctl write", 64'(ctl_o), 64'h44);
    c = mk(1, 4'd6, 3'd2, 8'h00);
    access(c, w);
    chk("R7 ctl read", w, done_of(c, 8'h44));
    c = mk(1, 4'd6, 3'd1, 8'hFF);
    access(c, w);
    chk("R7 data read", w, done_of(c, 8'hA5));
  endtask

  task automatic t_shared();
    logic [63:0] c, w;
    access(mk(0, 4'd6, 3'd3, 8'h2B), w);
    chk("R8 clkctl write", 64'(clkctl_o), 64'h2B);
    status_i = 8'h5A;
    c = mk(1, 4'd6, 3'd3, 8'h00);
    access(c, w);
    chk("R8 status read", w, done_of(c, 8'h5A));
    chk("R8 clkctl kept", 64'(clkctl_o), 64'h2B);
  endtask

  task automatic t_unused();
    logic [63:0] c, w;
    int vcnt;
    c = mk(0, 4'd5, 3'd1, 8'h77);
    issue(c);
    vcnt = 1;
    for (int i = 0; i < 20 && host_word_o[63]; i++) begin
      @(negedge clk_i);
      if (host_word_o[63]) vcnt++;
    end
    chk("R10 unused completes", 64'(vcnt), 64'(LAT));
    access(mk(0, 4'd6, 3'd5, 8'h77), w);
    chk("R10 no effect", {32'h0, div_o, data_o, ctl_o, clkctl_o},
        {32'h0, 8'h3C, 8'hA5, 8'h44, 8'h2B});
    c = mk(1, 4'd5, 3'd0, 8'hEE);
    access(c, w);
    chk("R10 unused read", w, done_of(c, 8'h00));
    c = mk(1, 4'd6, 3'd7, 8'hEE);
    access(c, w);
    chk("R10 srst read zero", w, done_of(c, 8'h00));
    chk("R10 srst read no reset", 64'(div_o), 64'h3C);
  endtask

  task automatic t_busy();
    logic [63:0] a, b, w;
    a = mk(0, 4'd6, 3'd1, 8'h11);
    b = mk(0, 4'd6, 3'd1, 8'h99);
    issue(a);
    issue(b);
    wait_idle(w);
    chk("R4 mid-busy write dropped", w, done_of(a, 8'h00));
    chk("R4 data from first", 64'(data_o), 64'h11);
    // second write lands in the completion cycle of the first
    a = mk(0, 4'd6, 3'd1, 8'h22);
    issue(a);
    for (int i = 0; i < LAT - 2; i++) @(negedge clk_i);
    issue(b);
    chk("R4 collision word", host_word_o, done_of(a, 8'h00));
    repeat (LAT + 1) @(negedge clk_i);
    chk("R4 collision stays idle", host_word_o, done_of(a, 8'h00));
    chk("R4 collision data", 64'(data_o), 64'h22);
  endtask

  task automatic t_novalid();
    logic [63:0] prev, c;
    prev = host_word_o;
    c = mk(0, 4'd6, 3'd1, 8'h55);
    c[63] = 1'b0;
    issue(c);
    repeat (LAT + 1) @(negedge clk_i);
    chk("R5 word unchanged", host_word_o, prev);
    chk("R5 data unchanged", 64'(data_o), 64'h22);
  endtask

  task automatic t_srst();
    logic [63:0] w;
    access(mk(0, 4'd6, 3'd7, 8'h00), w);
    chk("R9 soft reset", {32'h0, div_o, data_o, ctl_o, clkctl_o},
        {32'h0, 8'h18, 8'h00, 8'h00, 8'h00});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_timing();
    t_div();
    t_ctl_data();
    t_shared();
    t_unused();
    t_busy();
    t_novalid();
    t_srst();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule